// File: doc/BRIEF.md
# Dual-Tone Stepped Sine Synthesizer

This block produces the digital sample stream for a keypad signalling tone pair. It runs from a 3.579545 MHz reference clock and holds two tone channels, one for the low-frequency group and one for the high-frequency group. Each channel has a programmable divide-by-N counter. The counter sets how long each amplitude step lasts, and a 28-step phase sequencer walks one sine cycle through those steps.

A keypad controller drives a 2-bit row index, a 2-bit column index and one enable per group. The block looks up a stepped sine value for each channel and scales the high channel up by about 2.7 dB. It adds the two values and registers the result as a signed two's-complement word on every clock. That word then goes to an external converter. When both groups are off, the word sits at zero, which stands for the DC offset level.

Top module: `dtmf_synth`

## Requirements
- R1: While `rst_n` is low, and after it is released until a group is enabled, `sample_o` is 0.
- R2: With the low group enabled, row index 0, 1, 2 and 3 hold each amplitude step for 184, 166, 150 and 136 clock cycles respectively.
- R3: With the high group enabled, column index 0, 1, 2 and 3 hold each amplitude step for 106, 96, 86 and 78 clock cycles respectively.
- R4: A channel's phase runs through steps 0 to 27 and returns to step 0 after step 27, so one tone cycle spans exactly 28 steps.
- R5: The low-channel value at step k is round(1000·|sin(2πk/28)|), with the sign of sin(2πk/28).
- R6: The high-channel value at step k is floor(m·87/64), where m is the low-channel magnitude at step k, and it carries the same sign.
- R7: `sample_o` is the registered sum of both channel values. An enabled channel holds step 0 for the first N+1 clock edges after its enable is first sampled, and it advances once every N edges after that.
- R8: When a group is disabled, its phase returns to step 0 and it contributes 0. When it is enabled again, it restarts from step 0 with a full step period.
- R9: The row or column index of a disabled group has no effect on `sample_o`.
- R10: When both groups have been disabled for two consecutive clock edges, `sample_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 3.579545 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| low_en | input | 1 | Enables the low-group tone |
| high_en | input | 1 | Enables the high-group tone |
| row_idx | input | 2 | Selects the low-group frequency (row) |
| col_idx | input | 2 | Selects the high-group frequency (column) |
| sample_o | output | 16 | Signed sum of both tone samples |

## Verification
Two events can land in the same clock edge. One is a channel's terminal count, which would advance its phase. The other is the removal of that channel's enable, which must force the phase back to step 0. The bench provokes this by dropping the low-group enable on exactly the edge where its step pulse fires, and then enabling the group again. It judges the result against a cycle-accurate model built from the requirements. That model expects the channel's contribution to reach zero and the tone to restart at step 0 with a full step period. A second collision is a phase wrap from step 27 to 0 in one channel during a step change in the other. The dual-tone run covers this, with every cycle compared against the model.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int STEPS   = 28;
  localparam int PHASE_W = $clog2(STEPS);
  localparam int DIV_W   = 8;
  localparam int MAG_W   = 10;
  localparam int AMP_W   = 11;
  localparam int SAMPLE_W = AMP_W + 1;

  function automatic logic [DIV_W-1:0] low_ratio(input logic [1:0] idx);
    case (idx)
      2'd0:    return DIV_W'(184);
      2'd1:    return DIV_W'(166);
      2'd2:    return DIV_W'(150);
      default: return DIV_W'(136);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] high_ratio(input logic [1:0] idx);
    case (idx)
      2'd0:    return DIV_W'(106);
      2'd1:    return DIV_W'(96);
      2'd2:    return DIV_W'(86);
      default: return DIV_W'(78);
    endcase
  endfunction

  // First quarter of one 28-step sine cycle, amplitude 1000
  function automatic logic [MAG_W-1:0] quarter_mag(input logic [2:0] i);
    case (i)
      3'd0:    return MAG_W'(0);
      3'd1:    return MAG_W'(223);
      3'd2:    return MAG_W'(434);
      3'd3:    return MAG_W'(623);
      3'd4:    return MAG_W'(782);
      3'd5:    return MAG_W'(901);
      3'd6:    return MAG_W'(975);
      default: return MAG_W'(1000);
    endcase
  endfunction

  function automatic logic [MAG_W-1:0] step_mag(input logic [PHASE_W-1:0] p);
    if (p <= PHASE_W'(7))       return quarter_mag(p[2:0]);
    else if (p <= PHASE_W'(14)) return quarter_mag(3'(PHASE_W'(14) - p));
    else if (p <= PHASE_W'(21)) return quarter_mag(3'(p - PHASE_W'(14)));
    else                        return quarter_mag(3'(PHASE_W'(28) - p));
  endfunction

  function automatic logic step_neg(input logic [PHASE_W-1:0] p);
    return p >= PHASE_W'(15);
  endfunction
endpackage

// File: rtl/tone_divider.sv
module tone_divider
  import dtmf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] ratio,
  output logic             step
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    step = en && (cnt_q >= ratio - 1'b1);
    if (!en || step) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_STEP_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import dtmf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               step,
  output logic [PHASE_W-1:0] phase
);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(STEPS - 1);
  logic [PHASE_W-1:0] phase_q, phase_d;

  always_comb begin
    if (!en)       phase_d = '0;
    else if (step) phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    else           phase_d = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < PHASE_W'(STEPS)); // R4
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && phase_q == LAST) |=> (phase_q == '0)); // R4
  AST_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (phase_q == '0)); // R8
  AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !step) |=> $stable(phase_q)); // R2
endmodule

// File: rtl/sine_lut.sv
module sine_lut
  import dtmf_pkg::*;
#(
  parameter int GAIN_NUM   = 64,
  parameter int GAIN_SHIFT = 6
)(
  input  logic [PHASE_W-1:0]        phase,
  output logic signed [SAMPLE_W-1:0] sample
);
  localparam int PROD_W = MAG_W + 8;
  logic [PROD_W-1:0] prod;
  logic [AMP_W-1:0]  scaled;

  always_comb begin
    prod   = PROD_W'(step_mag(phase)) * PROD_W'(GAIN_NUM);
    scaled = AMP_W'(prod >> GAIN_SHIFT);
    if (step_neg(phase)) sample = -$signed({1'b0, scaled});
    else                 sample =  $signed({1'b0, scaled});
  end
endmodule

// File: rtl/tone_channel.sv
module tone_channel
  import dtmf_pkg::*;
#(
  parameter int GAIN_NUM   = 64,
  parameter int GAIN_SHIFT = 6
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [DIV_W-1:0]           ratio,
  output logic signed [SAMPLE_W-1:0] sample
);
  logic               step;
  logic [PHASE_W-1:0] phase;

  tone_divider u_div (.clk(clk), .rst_n(rst_n), .en(en), .ratio(ratio), .step(step));
  phase_seq    u_seq (.clk(clk), .rst_n(rst_n), .en(en), .step(step), .phase(phase));
  sine_lut #(.GAIN_NUM(GAIN_NUM), .GAIN_SHIFT(GAIN_SHIFT))
    u_lut (.phase(phase), .sample(sample));
endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
  import dtmf_pkg::*;
#(
  parameter int OUT_W     = 16,
  parameter int HI_GAIN   = 87,
  parameter int GAIN_SHFT = 6
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    low_en,
  input  logic                    high_en,
  input  logic [1:0]              row_idx,
  input  logic [1:0]              col_idx,
  output logic signed [OUT_W-1:0] sample_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic signed [SAMPLE_W-1:0] low_s, high_s;
  logic signed [OUT_W-1:0]    sum_d, sum_q;

  tone_channel #(.GAIN_NUM(1 << GAIN_SHFT), .GAIN_SHIFT(GAIN_SHFT)) u_low (
    .clk(clk), .rst_n(rst_n_int), .en(low_en),
    .ratio(low_ratio(row_idx)), .sample(low_s));

  tone_channel #(.GAIN_NUM(HI_GAIN), .GAIN_SHIFT(GAIN_SHFT)) u_high (
    .clk(clk), .rst_n(rst_n_int), .en(high_en),
    .ratio(high_ratio(col_idx)), .sample(high_s));

  always_comb sum_d = OUT_W'(low_s) + OUT_W'(high_s);

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) sum_q <= '0;
    else            sum_q <= sum_d;
  end

  assign sample_o = sum_q;

  AST_IDLE_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!low_en && !high_en && $past(!low_en && !high_en)) |=> (sample_o == '0)); // R10
endmodule

// File: tb/tb_dtmf_synth.sv
module tb_dtmf_synth;
  logic clk = 1'b0;
  logic rst_n;
  logic le, he;
  logic [1:0] row, col;
  logic signed [15:0] sample_o;

  int tests = 0, fails = 0;
  bit done = 0;
  int kL = 0, kH = 0, pL_prev = 0, pH_prev = 0;
  int model_err = 0, last_act = 0, last_exp = 0;

  always #2.5 clk = ~clk;

  dtmf_synth dut (.clk(clk), .rst_n(rst_n), .low_en(le), .high_en(he),
                  .row_idx(row), .col_idx(col), .sample_o(sample_o));

  function automatic int nlow(input logic [1:0] i);
    case (i) 0: return 184; 1: return 166; 2: return 150; default: return 136; endcase
  endfunction
  function automatic int nhigh(input logic [1:0] i);
    case (i) 0: return 106; 1: return 96; 2: return 86; default: return 78; endcase
  endfunction
  function automatic int ref_val(input int p, input bit hi);
    real s;
    int m;
    s = $sin(2.0 * 3.14159265358979 * p / 28.0);
    m = $rtoi((s < 0.0 ? -s : s) * 1000.0 + 0.5);
    if (hi) m = (m * 87) / 64;
    return (s < 0.0) ? -m : m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock edge through the requirement-level model, compare at the falling edge
  task automatic tick(output int act);
    int pL, pH, exp;
    @(posedge clk);
    kL = le ? kL + 1 : 0;
    kH = he ? kH + 1 : 0;
    pL = le ? (kL / nlow(row)) % 28 : 0;
    pH = he ? (kH / nhigh(col)) % 28 : 0;
    exp = ref_val(pL_prev, 1'b0) + ref_val(pH_prev, 1'b1);
    pL_prev = pL;
    pH_prev = pH;
    @(negedge clk);
    act = sample_o;
    if (act != exp && model_err == 0) begin
      last_act = act;
      last_exp = exp;
    end
    if (act != exp) model_err++;
  endtask

  task automatic model_check(input string req);
    check(model_err == 0, req, last_act, last_exp);
    model_err = 0;
  endtask

  task automatic t_reset;
    le = 0; he = 0; row = 0; col = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(sample_o == 0, "R1 in reset", sample_o, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(sample_o == 0, "R1 after release", sample_o, 0);
  endtask

  // Steps per group index, phase wrap and table shape
  task automatic t_ratio(input bit hi, input logic [1:0] idx);
    int act, prev, changes, last_t, t, n, bad_iv, v28, v29;
    string rq;
    n = hi ? nhigh(idx) : nlow(idx);
    rq = hi ? "R3" : "R2";
    if (hi) begin col = idx; he = 1; end else begin row = idx; le = 1; end
    prev = 0; changes = 0; last_t = 0; t = 0; bad_iv = 0; v28 = 1; v29 = 0;
    while (changes < 30 && t < 8000) begin
      tick(act);
      t++;
      if (act != prev) begin
        changes++;
        if (changes > 1 && t - last_t != n) bad_iv = t - last_t;
        if (changes == 28) v28 = act;
        if (changes == 29) v29 = act;
        last_t = t;
        prev = act;
      end
    end
    check(bad_iv == 0 && changes == 30, rq, bad_iv, n);
    check(v28 == 0, "R4 wrap to step 0", v28, 0);
    check(v29 == ref_val(1, hi), "R4 step 1 after wrap", v29, ref_val(1, hi));
    model_check(hi ? "R6 high table" : "R5 low table");
    le = 0; he = 0;
    tick(act); tick(act); tick(act);
    check(act == 0, "R10 idle after disable", act, 0);
    model_err = 0;
  endtask

  task automatic t_dual;
    int act;
    row = 2; col = 1; le = 1; he = 1;
    repeat (6000) tick(act);
    model_check("R7 dual-tone sum");
    le = 0; he = 0;
    repeat (3) tick(act);
    model_err = 0;
  endtask

  // Disable lands on the very edge of a step pulse, then re-enable
  task automatic t_restart;
    int act;
    row = 0; le = 1; he = 1; col = 3;
    repeat (3 * 184 - 1) tick(act);
    le = 0;
    repeat (4) tick(act);
    model_check("R8 zero contribution while off");
    le = 1;
    repeat (800) tick(act);
    model_check("R8 restart from step 0");
    le = 0; he = 0;
    repeat (3) tick(act);
    model_err = 0;
  endtask

  task automatic t_ignore;
    int act;
    he = 1; col = 2; le = 0;
    for (int i = 0; i < 2000; i++) begin
      row = 2'(i);
      tick(act);
    end
    model_check("R9 row index ignored while off");
    he = 0;
    repeat (3) tick(act);
    check(act == 0, "R10 idle", act, 0);
    model_err = 0;
  endtask

  initial begin
    t_reset();
    for (int i = 0; i < 4; i++) t_ratio(1'b0, 2'(i));
    for (int i = 0; i < 4; i++) t_ratio(1'b1, 2'(i));
    t_dual();
    t_restart();
    t_ignore();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule